// File: doc/BRIEF.md
# Shift and Rotate Unit

This block performs one shift or rotate operation per valid cycle on an operand of 1, 2, 4 or 8 bytes. It supports logical left, logical right and arithmetic right shifts, plain rotates in both directions, and rotates in both directions that pass through the carry flag. The count comes either from a register operand or from an 8-bit immediate. It is masked according to the operand size before use.

The result of the selected size is written into the previous destination value, and bits above the operand width keep their old contents. When the per-flag enable bits are set and the masked count is non-zero, the carry and overflow flags are rewritten from the bits that leave the operand. Result and flags are registered, so they appear one cycle after the request.

Top module: `shf_unit`

## Requirements
- R1: The count source is `amt_imm_i` when `use_imm_i` is 1 and `amt_reg_i` otherwise. For size code 3 (8 bytes), only its low 6 bits count. For size codes 0, 1 and 2 (1, 2 and 4 bytes), only its low 5 bits count.
- R2: Op code 0 shifts left and op code 1 shifts right logically. Both fill vacated bits with zeros. A masked count that is at least the operand width gives an all-zero field.
- R3: Op code 2 shifts right arithmetically and fills vacated bits with the operand's top bit. A masked count that is at least the width gives a field made entirely of that bit.
- R4: Op code 3 rotates right and op code 4 rotates left. Both work within the operand width, and the count is taken modulo the width.
- R5: Op code 5 rotates right and op code 6 rotates left through carry. The rotation runs over width+1 bits, with `cf_i` placed above the operand, and the count is taken modulo width+1. A right rotate by n puts the old carry at bit width-n. A left rotate by n puts it at bit n-1.
- R6: For op codes 3 to 6, a masked count of zero returns `dest_i` unchanged in all bits and leaves both flags at their inputs.
- R7: The operand field is the low 8 << size bits. All result bits above that field come from `dest_i`.
- R8: When `flag_en_i[0]` is 1 and the masked count is non-zero, `cf_o` takes the last bit moved out. For left shifts this is src[width-n]. For right shifts it is src[n-1], or 0 (logical) or the sign (arithmetic) once n exceeds the width. For plain rotates it is the result's top bit (right) or bottom bit (left). For carry rotates it is the new bit above the operand. Otherwise `cf_o` equals `cf_i`.
- R9: When `flag_en_i[1]` is 1 and the masked count is non-zero, `of_o` is computed from the result and the computed carry-out, whatever the value of `flag_en_i[0]`. For left ops (codes 0, 4 and 6) it is result[width-1] XOR that carry-out. For right ops it is result[width-1] XOR result[width-2]. Otherwise `of_o` equals `of_i`.
- R10: Outputs are registered. `valid_o` follows `valid_i` one cycle later. Result and flags hold while `valid_i` is 0. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Operand size code, width 8 << size_i |
| use_imm_i | input | 1 | Select immediate count |
| amt_reg_i | input | 64 | Register count operand |
| amt_imm_i | input | 8 | Immediate count operand |
| src_i | input | 64 | Source operand |
| dest_i | input | 64 | Previous destination value |
| cf_i | input | 1 | Current carry flag |
| of_i | input | 1 | Current overflow flag |
| flag_en_i | input | 2 | Flag write enables: bit 0 carry, bit 1 overflow |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Merged result |
| cf_o | output | 1 | Carry flag out |
| of_o | output | 1 | Overflow flag out |

## Verification
A carry rotate both consumes the incoming carry as a data bit and produces a new carry in the same cycle. The bench provokes this with right and left carry rotates by one, with `cf_i` set and the carry enable on. It then checks that the old carry lands at the expected bit of `result_o`, while `cf_o` in that same registered cycle carries the bit that left the operand. Counts of exactly width+1 are also applied. Here the data stays put while the flag update still fires, which separates the rotate path from the flag path.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [2:0] {
    SHF_SLL = 3'd0,
    SHF_SRL = 3'd1,
    SHF_SRA = 3'd2,
    SHF_ROR = 3'd3,
    SHF_ROL = 3'd4,
    SHF_RCR = 3'd5,
    SHF_RCL = 3'd6
  } shf_op_e;
endpackage

// File: rtl/shf_count.sv
module shf_count #(
  parameter int DATA_W    = 64,
  parameter int IMM_W     = 8,
  parameter int SIZE_W    = 2,
  parameter int NUM_SIZES = 4,
  localparam int CNT_W    = $clog2(DATA_W)
) (
  input  logic              use_imm_i,
  input  logic [CNT_W-1:0]  amt_reg_i,
  input  logic [CNT_W-1:0]  amt_imm_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              zero_o
);
  localparam logic [SIZE_W-1:0] SIZE_TOP = SIZE_W'(NUM_SIZES - 1);

  logic [CNT_W-1:0] raw;

  always_comb begin
    raw    = use_imm_i ? amt_imm_i : amt_reg_i;
    cnt_o  = (size_i == SIZE_TOP) ? raw : {1'b0, raw[CNT_W-2:0]};
    zero_o = (cnt_o == '0);
  end
endmodule

// File: rtl/shf_lane.sv
module shf_lane
  import shf_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 6
) (
  input  shf_op_e          op_i,
  input  logic [W-1:0]     x_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cf_i,
  output logic [W-1:0]     res_o,
  output logic             cf_o,
  output logic             of_o
);
  localparam int M  = W + 1;
  localparam int RW = $clog2(W);

  logic [W:0]        sl, sr;
  logic signed [W:0] sa;
  logic [RW-1:0]     r_plain;
  logic [W-1:0]      ror_v, rol_v;
  logic [CNT_W-1:0]  r_carry;
  logic [M-1:0]      y, rcr_v, rcl_v;
  logic              left;

  always_comb begin
    // extra bit beside the operand catches the last bit shifted out
    sl      = {1'b0, x_i} << cnt_i;
    sr      = {x_i, 1'b0} >> cnt_i;
    sa      = $signed({x_i, 1'b0}) >>> cnt_i;
    r_plain = cnt_i[RW-1:0];
    ror_v   = (x_i >> r_plain) | (x_i << (W - int'(r_plain)));
    rol_v   = (x_i << r_plain) | (x_i >> (W - int'(r_plain)));
    r_carry = CNT_W'(int'(cnt_i) % M);
    y       = {cf_i, x_i};
    rcr_v   = (y >> r_carry) | (y << (M - int'(r_carry)));
    rcl_v   = (y << r_carry) | (y >> (M - int'(r_carry)));

    left  = 1'b0;
    res_o = x_i;
    cf_o  = cf_i;
    unique case (op_i)
      SHF_SLL: begin res_o = sl[W-1:0];    cf_o = sl[W];     left = 1'b1; end
      SHF_SRL: begin res_o = sr[W:1];      cf_o = sr[0];                  end
      SHF_SRA: begin res_o = sa[W:1];      cf_o = sa[0];                  end
      SHF_ROR: begin res_o = ror_v;        cf_o = ror_v[W-1];             end
      SHF_ROL: begin res_o = rol_v;        cf_o = rol_v[0];  left = 1'b1; end
      SHF_RCR: begin res_o = rcr_v[W-1:0]; cf_o = rcr_v[W];               end
      SHF_RCL: begin res_o = rcl_v[W-1:0]; cf_o = rcl_v[W];  left = 1'b1; end
      default: ;
    endcase
    of_o = left ? (res_o[W-1] ^ cf_o) : (res_o[W-1] ^ res_o[W-2]);
  end
endmodule

// File: rtl/shf_merge.sv
module shf_merge #(
  parameter int DATA_W    = 64,
  parameter int SIZE_W    = 2,
  parameter int NUM_SIZES = 4
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [DATA_W-1:0] dest_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              keep_i,
  output logic [DATA_W-1:0] out_o
);
  logic [DATA_W-1:0] mask;

  always_comb begin
    mask = '1;
    for (int i = 0; i < NUM_SIZES; i++) begin
      if (size_i == SIZE_W'(i)) mask = {DATA_W{1'b1}} >> (DATA_W - (8 << i));
    end
    out_o = keep_i ? dest_i : ((val_i & mask) | (dest_i & ~mask));
  end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int IMM_W      = 8,
  localparam int NUM_SIZES = $clog2(DATA_W / 8) + 1,
  localparam int SIZE_W    = $clog2(NUM_SIZES),
  localparam int CNT_W     = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] amt_reg_i,
  input  logic [IMM_W-1:0]  amt_imm_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dest_i,
  input  logic              cf_i,
  input  logic              of_i,
  input  logic [1:0]        flag_en_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              cf_o,
  output logic              of_o
);
  shf_op_e           op_e;
  logic [CNT_W-1:0]  cnt;
  logic              cnt_zero, is_rot, keep;
  logic [DATA_W-1:0] lane_res [NUM_SIZES];
  logic              lane_cf  [NUM_SIZES];
  logic              lane_of  [NUM_SIZES];
  logic [DATA_W-1:0] merged;
  logic              cf_n, of_n;
  logic              unused_amt;

  assign op_e       = shf_op_e'(op_i);
  assign unused_amt = ^{amt_reg_i[DATA_W-1:CNT_W], amt_imm_i[IMM_W-1:CNT_W]};

  shf_count #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .SIZE_W(SIZE_W), .NUM_SIZES(NUM_SIZES)
  ) u_count (
    .use_imm_i(use_imm_i),
    .amt_reg_i(amt_reg_i[CNT_W-1:0]),
    .amt_imm_i(amt_imm_i[CNT_W-1:0]),
    .size_i   (size_i),
    .cnt_o    (cnt),
    .zero_o   (cnt_zero)
  );

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
    localparam int LW = 8 << g;
    logic [LW-1:0] res_w;
    shf_lane #(.W(LW), .CNT_W(CNT_W)) u_lane (
      .op_i (op_e),
      .x_i  (src_i[LW-1:0]),
      .cnt_i(cnt),
      .cf_i (cf_i),
      .res_o(res_w),
      .cf_o (lane_cf[g]),
      .of_o (lane_of[g])
    );
    assign lane_res[g] = DATA_W'(res_w);
  end

  assign is_rot = op_e inside {SHF_ROR, SHF_ROL, SHF_RCR, SHF_RCL};
  assign keep   = is_rot && cnt_zero;

  shf_merge #(.DATA_W(DATA_W), .SIZE_W(SIZE_W), .NUM_SIZES(NUM_SIZES)) u_merge (
    .val_i (lane_res[size_i]),
    .dest_i(dest_i),
    .size_i(size_i),
    .keep_i(keep),
    .out_o (merged)
  );

  assign cf_n = (flag_en_i[0] && !cnt_zero) ? lane_cf[size_i] : cf_i;
  assign of_n = (flag_en_i[1] && !cnt_zero) ? lane_of[size_i] : of_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      cf_o     <= 1'b0;
      of_o     <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= merged;
        cf_o     <= cf_n;
        of_o     <= of_n;
      end
    end
  end
endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
  parameter int DATA_W     = 64,
  localparam int NUM_SIZES = $clog2(DATA_W / 8) + 1,
  localparam int SIZE_W    = $clog2(NUM_SIZES),
  localparam int CNT_W     = $clog2(DATA_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [SIZE_W-1:0] size_i,
  input logic              use_imm_i,
  input logic [CNT_W-1:0]  amt_reg_lo_i,
  input logic [CNT_W-1:0]  amt_imm_lo_i,
  input logic [7:0]        src_lo_i,
  input logic [DATA_W-1:0] dest_i,
  input logic              cf_i,
  input logic              of_i,
  input logic [1:0]        flag_en_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              cf_o,
  input logic              of_o
);
  logic [CNT_W-1:0] raw_c, eff_c;
  logic             rot_op;

  assign raw_c  = use_imm_i ? amt_imm_lo_i : amt_reg_lo_i;
  assign eff_c  = (size_i == SIZE_W'(NUM_SIZES - 1)) ? raw_c : {1'b0, raw_c[CNT_W-2:0]};
  assign rot_op = (op_i >= 3'd3) && (op_i <= 3'd6);

  assert_valid_pipe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(cf_o) && $stable(of_o)));

  assert_rot_zero_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rot_op && eff_c == '0) |=>
      (result_o == $past(dest_i) && cf_o == $past(cf_i) && of_o == $past(of_i)));

  assert_upper_merge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == '0) |=> (result_o[DATA_W-1:8] == $past(dest_i[DATA_W-1:8])));

  assert_flags_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && flag_en_i == 2'b00) |=> (cf_o == $past(cf_i) && of_o == $past(of_i)));

  assert_sll_wide_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd0 && size_i == '0 && eff_c >= CNT_W'(8)) |=> (result_o[7:0] == 8'h00));

  assert_sra_wide_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd2 && size_i == '0 && eff_c >= CNT_W'(8)) |=>
      (result_o[7:0] == {8{$past(src_lo_i[7])}}));
endmodule

bind shf_unit shf_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .op_i        (op_i),
  .size_i      (size_i),
  .use_imm_i   (use_imm_i),
  .amt_reg_lo_i(amt_reg_i[CNT_W-1:0]),
  .amt_imm_lo_i(amt_imm_i[CNT_W-1:0]),
  .src_lo_i    (src_i[7:0]),
  .dest_i      (dest_i),
  .cf_i        (cf_i),
  .of_i        (of_i),
  .flag_en_i   (flag_en_i),
  .valid_o     (valid_o),
  .result_o    (result_o),
  .cf_o        (cf_o),
  .of_o        (of_o)
);

// File: tb/shf_unit_tb.sv
`timescale 1ns/1ps
module shf_unit_tb;
  localparam logic [63:0] D = 64'h1122334455667788;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  size;
    logic [7:0]  amt;
    logic [63:0] src;
    logic        cf;
    logic [63:0] res;
    logic        cfo;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd0, 8'd1,    64'h81,               1'b0, 64'h1122334455667702, 1'b1}, // R2 R8
    '{3'd1, 2'd0, 8'd5,    64'hF0,               1'b0, 64'h1122334455667707, 1'b1}, // R2 R8
    '{3'd2, 2'd0, 8'd2,    64'h84,               1'b0, 64'h11223344556677E1, 1'b0}, // R3
    '{3'd2, 2'd0, 8'd20,   64'h80,               1'b0, 64'h11223344556677FF, 1'b1}, // R3 wide
    '{3'd0, 2'd1, 8'd16,   64'h8001,             1'b0, 64'h1122334455660000, 1'b1}, // R2 wide
    '{3'd3, 2'd0, 8'd1,    64'h01,               1'b0, 64'h1122334455667780, 1'b1}, // R4
    '{3'd4, 2'd0, 8'd12,   64'h12,               1'b0, 64'h1122334455667721, 1'b1}, // R4 modulo
    '{3'd5, 2'd0, 8'd1,    64'h02,               1'b1, 64'h1122334455667781, 1'b0}, // R5
    '{3'd6, 2'd0, 8'd1,    64'h40,               1'b1, 64'h1122334455667781, 1'b0}, // R5
    '{3'd5, 2'd0, 8'd9,    64'h5A,               1'b1, 64'h112233445566775A, 1'b1}, // R5 width+1
    '{3'd3, 2'd0, 8'd0,    64'h5A,               1'b1, D,                    1'b1}, // R6
    '{3'd3, 2'd3, 8'd64,   64'h5A,               1'b0, D,                    1'b0}, // R1 R6
    '{3'd0, 2'd3, 8'h41,   64'h8000000000000001, 1'b0, 64'h0000000000000002, 1'b1}, // R1
    '{3'd0, 2'd2, 8'h21,   64'h80000001,         1'b0, 64'h1122334400000002, 1'b1}, // R1 R7
    '{3'd6, 2'd1, 8'd17,   64'hBEEF,             1'b0, 64'h112233445566BEEF, 1'b0}, // R5 R7
    '{3'd1, 2'd0, 8'd0,    64'h5A,               1'b0, 64'h112233445566775A, 1'b0}  // R8 zero count
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic        use_imm_i = 1'b0;
  logic [63:0] amt_reg_i = '0;
  logic [7:0]  amt_imm_i = '0;
  logic [63:0] src_i = '0;
  logic [63:0] dest_i = '0;
  logic        cf_i = 1'b0;
  logic        of_i = 1'b0;
  logic [1:0]  flag_en_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic        cf_o;
  logic        of_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  shf_unit u_dut (
    .clk_i, .rst_ni, .valid_i, .op_i, .size_i, .use_imm_i, .amt_reg_i,
    .amt_imm_i, .src_i, .dest_i, .cf_i, .of_i, .flag_en_i,
    .valid_o, .result_o, .cf_o, .of_o
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [1:0] size, input logic imm_sel,
                       input logic [63:0] areg, input logic [7:0] aimm,
                       input logic [63:0] src, input logic [63:0] dest,
                       input logic cf, input logic of, input logic [1:0] fen);
    @(negedge clk_i);
    op_i = op; size_i = size; use_imm_i = imm_sel; amt_reg_i = areg; amt_imm_i = aimm;
    src_i = src; dest_i = dest; cf_i = cf; of_i = of; flag_en_i = fen; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10 reset valid", 64'(valid_o), 64'h0);
    check("R10 reset result", result_o, 64'h0);
    check("R10 reset flags", 64'({cf_o, of_o}), 64'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].size, 1'(i % 2), 64'(VECS[i].amt), VECS[i].amt,
            VECS[i].src, D, VECS[i].cf, 1'b0, 2'b01);
      check($sformatf("R2-7 vector %0d result", i), result_o, VECS[i].res);
      check($sformatf("R8 vector %0d carry", i), 64'(cf_o), 64'(VECS[i].cfo));
      check($sformatf("R10 vector %0d valid", i), 64'(valid_o), 64'h1);
    end

    // R1: immediate versus register count
    apply(3'd0, 2'd0, 1'b1, 64'd2, 8'd5, 64'h01, D, 1'b0, 1'b0, 2'b00);
    check("R1 imm count", result_o, 64'h1122334455667720);
    apply(3'd0, 2'd0, 1'b0, 64'd2, 8'd5, 64'h01, D, 1'b0, 1'b0, 2'b00);
    check("R1 reg count", result_o, 64'h1122334455667704);

    // R8: flags disabled keep inputs
    apply(3'd0, 2'd0, 1'b0, 64'd1, 8'd0, 64'h80, D, 1'b0, 1'b1, 2'b00);
    check("R8 flags off cf", 64'(cf_o), 64'h0);
    check("R9 flags off of", 64'(of_o), 64'h1);

    // R9: overflow on left op, carry not enabled
    apply(3'd0, 2'd0, 1'b0, 64'd1, 8'd0, 64'h40, D, 1'b1, 1'b0, 2'b10);
    check("R9 left result", result_o, 64'h1122334455667780);
    check("R9 left cf held", 64'(cf_o), 64'h1);
    check("R9 left of", 64'(of_o), 64'h1);

    // R9: overflow on right op
    apply(3'd1, 2'd0, 1'b0, 64'd1, 8'd0, 64'h80, D, 1'b1, 1'b0, 2'b11);
    check("R9 right result", result_o, 64'h1122334455667740);
    check("R9 right cf", 64'(cf_o), 64'h0);
    check("R9 right of", 64'(of_o), 64'h1);

    // R4: 64-bit rotate left by 63
    apply(3'd4, 2'd3, 1'b1, 64'd0, 8'd63, 64'h1, D, 1'b1, 1'b0, 2'b01);
    check("R4 rol64 result", result_o, 64'h8000000000000000);
    check("R4 rol64 cf", 64'(cf_o), 64'h0);

    // R2: 16-bit logical right by 31
    apply(3'd1, 2'd1, 1'b0, 64'd31, 8'd0, 64'hFFFF, D, 1'b1, 1'b0, 2'b01);
    check("R2 srl wide result", result_o, 64'h1122334455660000);
    check("R2 srl wide cf", 64'(cf_o), 64'h0);

    // R6 R1: count 32 at byte size masks to zero
    apply(3'd4, 2'd0, 1'b0, 64'd32, 8'd3, 64'h5A, D, 1'b0, 1'b1, 2'b11);
    check("R6 rot zero result", result_o, D);
    check("R6 rot zero of", 64'(of_o), 64'h1);

    // R10: idle inputs do not disturb outputs
    @(negedge clk_i);
    op_i = 3'd0; src_i = '1; dest_i = '0; amt_reg_i = 64'd1; cf_i = 1'b1; flag_en_i = 2'b11;
    @(negedge clk_i);
    check("R10 idle valid", 64'(valid_o), 64'h0);
    check("R10 idle hold", result_o, D);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule